// File: doc/BRIEF.md
# Streaming Bitonic Key Sorter

The block sorts sets of N unsigned keys into ascending order. A set enters as N/W consecutive beats of W keys and leaves the same way, W keys per cycle. Inside, a bitonic network of log2(N)·(log2(N)+1)/2 stages is laid out as a pipeline. Each stage has W/2 physical compare-exchange units, which together cover the stage's N/2 comparisons over N/W cycles. Between stages, a double-buffered memory reorders the set. A stage writes its results at computed element addresses into one page. The next stage then reads, also at computed addresses, the pairs it must compare.

A new set may start on the cycle after the last beat of the previous set, so the block sustains W keys per cycle. Idle cycles between sets are also accepted. Every set takes the same fixed latency, which depends only on N and W. N must be a power of two, and W must divide N with 2 <= W < N.

Top module: `streaming_bitonic_sorter`

## Requirements
- R1: Each output set is the input set in ascending unsigned order. Key index b*W+l sits in beat b, lane l, on bits l*DW+DW-1 down to l*DW of the data bus, for both input and output.
- R2: Duplicate keys are preserved: the output set holds every input key as many times as it was sent.
- R3: out_valid_o is high for exactly N/W consecutive cycles per set, with no gap inside a set.
- R4: The first output beat of a set appears exactly (S+1)*N/W cycles after the cycle of its first input beat, where S = log2(N)*(log2(N)+1)/2 (44 cycles for N=16, W=4).
- R5: Sets sent back-to-back leave back-to-back, in arrival order: the first beat of a set follows the previous set's last output beat on the very next cycle.
- R6: Idle cycles between input sets do not change the latency or the result of the next set.
- R7: During and after reset, out_valid_o stays low until a full input set has been taken. No output beat appears without a pending input set.
- R8: in_data_i is ignored while in_valid_i is low. Such data produces no output beat and does not alter any set.
- R9: Keys compare as unsigned values: a key with its top bit set orders above every key with a clear top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | An input beat is present |
| in_data_i | input | W*DW | W keys of the input beat, lane l at bits l*DW+:DW |
| out_valid_o | output | 1 | An output beat is present |
| out_data_o | output | W*DW | W sorted keys of the output beat, lane l at bits l*DW+:DW |

## Verification
For every set it sends, the bench records the cycle of the first input beat. It requires the first output beat exactly 44 cycles later, which is eleven memory stages of four cycles each. The remaining three beats must follow on consecutive cycles. Inputs are driven and outputs sampled on the falling edge, so each beat is checked in the cycle it is presented. For back-to-back sets, the first output beat must come on the cycle right after the previous set's last beat. After the final set, the bench drives idle cycles with changing data and expects out_valid_o to stay low throughout.

// File: rtl/sorter_pkg.sv
package sorter_pkg;

  // element index of the lower (up=0) or upper (up=1) member of pair q at distance 2**jl
  function automatic int pair_addr(int q, int jl, bit up);
    int lo;
    lo = ((q >> jl) << (jl + 1)) | (q & ((1 << jl) - 1));
    return up ? (lo | (1 << jl)) : lo;
  endfunction

  // jl < 0: natural order; otherwise lanes 2p/2p+1 carry pair beat*(w/2)+p
  function automatic int elem_addr(int beat, int lane, int jl, int w);
    if (jl < 0) return beat * w + lane;
    return pair_addr(beat * (w / 2) + lane / 2, jl, bit'(lane % 2));
  endfunction

  function automatic int num_stages(int lg);
    return lg * (lg + 1) / 2;
  endfunction

  function automatic int stage_jl(int s, int lg);
    int idx;
    idx = 0;
    for (int kl = 1; kl <= lg; kl++)
      for (int jl = kl - 1; jl >= 0; jl--) begin
        if (idx == s) return jl;
        idx++;
      end
    return 0;
  endfunction

  function automatic int stage_kl(int s, int lg);
    int idx;
    idx = 0;
    for (int kl = 1; kl <= lg; kl++)
      for (int jl = kl - 1; jl >= 0; jl--) begin
        if (idx == s) return kl;
        idx++;
      end
    return lg;
  endfunction

endpackage

// File: rtl/sorter_cmp_exch.sv
module sorter_cmp_exch #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] min_o,
  output logic [DW-1:0] max_o
);
  logic le;
  assign le    = a_i <= b_i;
  assign min_o = le ? a_i : b_i;
  assign max_o = le ? b_i : a_i;
endmodule

// File: rtl/sorter_perm_buf.sv
module sorter_perm_buf #(
  parameter int N     = 16,
  parameter int W     = 4,
  parameter int DW    = 16,
  parameter int WR_JL = -1,
  parameter int RD_JL = -1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic [W*DW-1:0] wr_data_i,
  output logic          rd_valid_o,
  output logic [W*DW-1:0] rd_data_o
);
  localparam int BEATS = N / W;
  localparam int BW    = $clog2(BEATS);
  localparam int AW    = $clog2(N);

  logic [DW-1:0] mem [2][N];
  logic [BW-1:0] wr_cnt, rd_cnt;
  logic          wr_page, rd_page, rd_act;
  logic          wr_last;

  assign wr_last = wr_valid_i && (wr_cnt == BW'(BEATS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_cnt  <= '0;
      wr_page <= 1'b0;
      rd_cnt  <= '0;
      rd_page <= 1'b0;
      rd_act  <= 1'b0;
    end else begin
      if (wr_valid_i) wr_cnt <= wr_last ? '0 : wr_cnt + 1'b1;
      if (wr_last) begin
        wr_page <= ~wr_page;
        rd_page <= wr_page;     // hand the full page to the reader
        rd_act  <= 1'b1;
        rd_cnt  <= '0;
      end else if (rd_act) begin
        rd_cnt <= rd_cnt + 1'b1;
        if (rd_cnt == BW'(BEATS - 1)) rd_act <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_valid_i)
      for (int l = 0; l < W; l++)
        mem[wr_page][AW'(sorter_pkg::elem_addr(int'(wr_cnt), l, WR_JL, W))] <= wr_data_i[l*DW +: DW];
  end

  for (genvar l = 0; l < W; l++) begin : g_rd
    assign rd_data_o[l*DW +: DW] = mem[rd_page][AW'(sorter_pkg::elem_addr(int'(rd_cnt), l, RD_JL, W))];
  end

  assign rd_valid_o = rd_act;
endmodule

// File: rtl/sorter_ce_stage.sv
module sorter_ce_stage #(
  parameter int N  = 16,
  parameter int W  = 4,
  parameter int DW = 16,
  parameter int JL = 0,
  parameter int KL = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [W*DW-1:0] data_i,
  output logic            valid_o,
  output logic [W*DW-1:0] data_o
);
  localparam int BEATS = N / W;
  localparam int BW    = $clog2(BEATS);

  logic [BW-1:0] beat;

  // beats arrive in whole runs of BEATS, so a free counter stays aligned
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      beat <= '0;
    else if (valid_i) beat <= beat + 1'b1;
  end

  for (genvar p = 0; p < W / 2; p++) begin : g_pair
    logic          asc;
    logic [DW-1:0] mn, mx;
    assign asc = ((sorter_pkg::pair_addr(int'(beat) * (W / 2) + p, JL, 1'b0) >> KL) & 1) == 0;
    sorter_cmp_exch #(.DW(DW)) u_cx (
      .a_i   (data_i[(2*p)*DW +: DW]),
      .b_i   (data_i[(2*p+1)*DW +: DW]),
      .min_o (mn),
      .max_o (mx)
    );
    assign data_o[(2*p)*DW +: DW]   = asc ? mn : mx;
    assign data_o[(2*p+1)*DW +: DW] = asc ? mx : mn;
  end

  assign valid_o = valid_i;
endmodule

// File: rtl/streaming_bitonic_sorter.sv
module streaming_bitonic_sorter #(
  parameter int N  = 16,
  parameter int W  = 4,
  parameter int DW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [W*DW-1:0] in_data_i,
  output logic            out_valid_o,
  output logic [W*DW-1:0] out_data_o
);
  localparam int LG = $clog2(N);
  localparam int S  = sorter_pkg::num_stages(LG);

  logic            wv [S+1];
  logic [W*DW-1:0] wd [S+1];
  logic            bv [S+1];
  logic [W*DW-1:0] bd [S+1];

  assign wv[0] = in_valid_i;
  assign wd[0] = in_data_i;

  for (genvar s = 0; s <= S; s++) begin : g_buf
    localparam int WJ = (s == 0) ? -1 : sorter_pkg::stage_jl(s - 1, LG);
    localparam int RJ = (s == S) ? -1 : sorter_pkg::stage_jl(s, LG);
    sorter_perm_buf #(.N(N), .W(W), .DW(DW), .WR_JL(WJ), .RD_JL(RJ)) u_buf (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_valid_i (wv[s]),
      .wr_data_i  (wd[s]),
      .rd_valid_o (bv[s]),
      .rd_data_o  (bd[s])
    );
  end

  for (genvar s = 0; s < S; s++) begin : g_stage
    sorter_ce_stage #(
      .N(N), .W(W), .DW(DW),
      .JL(sorter_pkg::stage_jl(s, LG)),
      .KL(sorter_pkg::stage_kl(s, LG))
    ) u_ce (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (bv[s]),
      .data_i  (bd[s]),
      .valid_o (wv[s+1]),
      .data_o  (wd[s+1])
    );
  end

  assign out_valid_o = bv[S];
  assign out_data_o  = bd[S];
endmodule

// File: rtl/sorter_checker.sv
module sorter_checker #(
  parameter int N  = 16,
  parameter int W  = 4,
  parameter int DW = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic            out_valid_i,
  input logic [W*DW-1:0] out_data_i
);
  localparam int BEATS = N / W;
  localparam int BW    = $clog2(BEATS);

  logic [BW-1:0] ocnt;
  logic [DW-1:0] prev_last;
  logic [31:0]   in_tot, out_tot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ocnt      <= '0;
      prev_last <= '0;
      in_tot    <= '0;
      out_tot   <= '0;
    end else begin
      if (in_valid_i) in_tot <= in_tot + 1;
      if (out_valid_i) begin
        out_tot   <= out_tot + 1;
        ocnt      <= ocnt + 1'b1;
        prev_last <= out_data_i[(W-1)*DW +: DW];
      end
    end
  end

  for (genvar l = 0; l < W - 1; l++) begin : g_lane
    AST_LANE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_i |-> out_data_i[l*DW +: DW] <= out_data_i[(l+1)*DW +: DW]); // R1
  end

  AST_BEAT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && ocnt != '0) |-> prev_last <= out_data_i[DW-1:0]); // R1

  AST_RUN_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_valid_i) |-> ocnt == '0); // R3

  AST_NO_EARLY_OUTPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i |-> out_tot < in_tot); // R7
endmodule

bind streaming_bitonic_sorter sorter_checker #(.N(N), .W(W), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .out_valid_i (out_valid_o),
  .out_data_i  (out_data_o)
);

// File: tb/sim_streaming_bitonic_sorter.sv
module sim_streaming_bitonic_sorter;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 16;
  localparam int W     = 4;
  localparam int DW    = 16;
  localparam int BEATS = N / W;
  localparam int LG    = 4;
  localparam int S     = LG * (LG + 1) / 2;
  localparam int LAT   = (S + 1) * BEATS;
  localparam int NROWS = 8;

  typedef struct packed {
    int kind;   // 0 hash, 1 ascending, 2 descending, 3 all equal, 4 few values, 5 top bit mix
    int seed;
    int gap;    // idle cycles before the set
  } row_t;

  localparam row_t ROWS [NROWS] = '{
    '{0, 1, 0}, '{2, 0, 0}, '{4, 5, 0}, '{0, 9, 0},
    '{3, 42, 3}, '{5, 0, 0}, '{1, 0, 7}, '{0, 77, 0}
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic [W*DW-1:0] in_data;
  logic            out_valid;
  logic [W*DW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [N*DW-1:0] exp_q[$];
  int start_q[$];
  int kind_q[$];
  int b2b_q[$];
  int gap_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  streaming_bitonic_sorter #(.N(N), .W(W), .DW(DW)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .in_data_i   (in_data),
    .out_valid_o (out_valid),
    .out_data_o  (out_data)
  );

  function automatic logic [DW-1:0] gen_key(int kind, int seed, int i);
    logic [31:0] t;
    case (kind)
      0: begin
        t = 32'(seed * 977 + i * 131 + 7) * 32'h9E3779B1;
        return t[31:16] ^ t[15:0];
      end
      1: return DW'(i * 3);
      2: return DW'(16'hFFFF - i);
      3: return DW'(seed);
      4: return DW'(((i * 7) % 3) * 100 + seed);
      default: return (i % 2 != 0) ? (DW'(16'h8000) | DW'(i)) : DW'(i);
    endcase
  endfunction

  function automatic logic [N*DW-1:0] sort_set(logic [N*DW-1:0] s);
    logic [DW-1:0] a [N];
    logic [DW-1:0] t;
    logic [N*DW-1:0] r;
    for (int i = 0; i < N; i++) a[i] = s[i*DW +: DW];
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N - 1 - i; j++)
        if (a[j] > a[j+1]) begin t = a[j]; a[j] = a[j+1]; a[j+1] = t; end
    for (int i = 0; i < N; i++) r[i*DW +: DW] = a[i];
    return r;
  endfunction

  task automatic send_set(int kind, int seed, int gap, int b2b);
    logic [N*DW-1:0] s;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = {$urandom, $urandom};   // R8 garbage while idle
    end
    for (int i = 0; i < N; i++) s[i*DW +: DW] = gen_key(kind, seed, i);
    for (int b = 0; b < BEATS; b++) begin
      @(negedge clk);
      if (b == 0) begin
        exp_q.push_back(sort_set(s));
        start_q.push_back(cyc);
        kind_q.push_back(kind);
        b2b_q.push_back(b2b);
        gap_q.push_back(gap);
      end
      in_valid = 1'b1;
      in_data  = s[b*W*DW +: W*DW];
    end
  endtask

  // monitor
  int obeat = 0;
  int prev_end = -100;
  logic [N*DW-1:0] cur_exp, got;
  int cur_kind;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (obeat == 0) begin
          if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R7 output beat with no pending set: actual=1 expected=0");
          end else begin
            int st, bb, gp;
            cur_exp = exp_q.pop_front();
            st = start_q.pop_front();
            cur_kind = kind_q.pop_front();
            bb = b2b_q.pop_front();
            gp = gap_q.pop_front();
            checks++;
            if (cyc != st + LAT) begin
              errors++;
              $display("FAIL R4 latency: actual=%0d expected=%0d", cyc - st, LAT);
            end
            if (bb != 0) begin
              checks++;
              if (cyc != prev_end + 1) begin
                errors++;
                $display("FAIL R5 back-to-back start: actual=%0d expected=%0d", cyc, prev_end + 1);
              end
            end
            if (gp != 0) begin
              checks++;
              if (cyc != st + LAT) begin
                errors++;
                $display("FAIL R6 latency after idle: actual=%0d expected=%0d", cyc - st, LAT);
              end
            end
          end
        end
        for (int l = 0; l < W; l++) got[(obeat*W + l)*DW +: DW] = out_data[l*DW +: DW];
        if (obeat == BEATS - 1) begin
          checks++;
          if (got !== cur_exp) begin
            errors++;
            if (cur_kind == 5)
              $display("FAIL R9 unsigned order: actual=%h expected=%h", got, cur_exp);
            else if (cur_kind == 3 || cur_kind == 4)
              $display("FAIL R2 duplicates: actual=%h expected=%h", got, cur_exp);
            else
              $display("FAIL R1 sorted set: actual=%h expected=%h", got, cur_exp);
          end
          prev_end = cyc;
          obeat = 0;
        end else begin
          obeat++;
        end
      end else if (obeat != 0) begin
        checks++; errors++;
        $display("FAIL R3 gap inside output set: actual=0 expected=1 at beat %0d", obeat);
        obeat = 0;
      end
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R4 watchdog expired: actual=hung expected=done");
    summary();
  end

  initial begin
    int seen;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R7 out_valid in reset: actual=%b expected=0", out_valid);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R7 out_valid after reset: actual=%b expected=0", out_valid);
    end

    for (int i = 0; i < NROWS; i++)
      send_set(ROWS[i].kind, ROWS[i].seed, ROWS[i].gap, (i > 0 && ROWS[i].gap == 0) ? 1 : 0);

    @(negedge clk);
    in_valid = 1'b0;
    while (exp_q.size() != 0 || obeat != 0) begin
      @(negedge clk);
      in_data = {$urandom, $urandom};
    end

    // R8: idle with changing data must produce nothing
    seen = 0;
    for (int c = 0; c < 80; c++) begin
      @(negedge clk);
      if (out_valid) seen++;
      in_data = {$urandom, $urandom};
    end
    checks++;
    if (seen != 0) begin
      errors++;
      $display("FAIL R8 output while idle: actual=%0d expected=0", seen);
    end

    // directed: all-maximum keys, single set after long idle (R9, R6)
    send_set(3, 16'hFFFF, 5, 0);
    @(negedge clk);
    in_valid = 1'b0;
    while (exp_q.size() != 0 || obeat != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule